// File: doc/BRIEF.md
# Two-Level Interrupt Mask Arbiter

This block chooses which interrupt, if any, is offered to the processor. It collects one non-maskable line, six external request lines and a parameterized group of internal peripheral lines. Each maskable source has an enable bit and a one-bit priority level. A mode input selects how the processor's mask bits are applied. In single-mask mode one mask bit blocks every maskable source. In two-level mode a second mask bit lets level-1 sources through while level-0 sources are held off.

The winner is presented as a registered request flag and a source index. The offer stays fixed until the processor pulses acknowledge, unless a request that outranks it appears. In that case the new request replaces the offer. The non-maskable line is edge-triggered and kept pending until it is acknowledged. Maskable lines are levels and are sampled on every clock.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_idx` is 0. Whenever no source is being offered, `irq_idx` reads 0.
- R2: A rising edge on `nmi_in` is presented as index 0 on the second clock edge after the rise, whatever the mask inputs are. A line held high does not trigger again after it is acknowledged.
- R3: While `standby` is 1, edges on `nmi_in` are ignored and any pending non-maskable request is discarded, so it is not presented.
- R4: A maskable source whose bit in `src_en` is 0 is never presented. Bits 0 to 5 of `src_en`, `src_lvl` belong to external lines 0 to 5, and bit 6+m belongs to peripheral line m.
- R5: With `mode_single`=1, all enabled maskable sources are accepted when `mask_all`=0 and none is accepted when `mask_all`=1, whatever `mask_lo` is.
- R6: With `mode_single`=0 and `mask_all`=0, all enabled maskable sources are accepted, whatever `mask_lo` is.
- R7: With `mode_single`=0, `mask_all`=1 and `mask_lo`=0, only sources whose `src_lvl` bit is 1 are accepted.
- R8: With `mode_single`=0, `mask_all`=1 and `mask_lo`=1, no maskable source is accepted.
- R9: The non-maskable request outranks every maskable one, and an accepted level-1 source outranks any level-0 source.
- R10: Within one level, the lower index wins. The indices are: non-maskable 0, external line n gives 1+n, and peripheral line m gives 7+m. A maskable request is presented on the first clock edge after it is sampled.
- R11: An offered request and its index stay unchanged until acknowledge, even if the source drops or an equal or lower-ranked request arrives. A higher-ranked request replaces the offer on the next edge.
- R12: An acknowledge while the non-maskable request is offered clears it. A new `nmi_in` rising edge sampled at the same edge as that acknowledge leaves it pending, and it is presented again one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Hardware standby; discards the non-maskable request |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| ext_req | input | NUM_EXT | External request levels |
| peri_req | input | NUM_PERI | Peripheral request levels |
| src_en | input | NUM_EXT+NUM_PERI | Per-source enable |
| src_lvl | input | NUM_EXT+NUM_PERI | Per-source priority level (1 = high) |
| mode_single | input | 1 | 1 = single mask bit, 0 = two-level masking |
| mask_all | input | 1 | Processor mask bit blocking maskable sources |
| mask_lo | input | 1 | Second mask bit, used in two-level mode |
| irq_ack | input | 1 | Acknowledge pulse from the processor |
| irq_req | output | 1 | Request to the processor |
| irq_idx | output | $clog2(1+NUM_EXT+NUM_PERI) | Index of the offered source |

## Verification
Two functions can fall on the same clock edge: the processor's acknowledge of an offered non-maskable request, and a fresh rising edge on `nmi_in` that would set the pending flag the acknowledge is clearing. The bench offers the non-maskable request, drops the line for one cycle, then raises it again in the same cycle as the acknowledge pulse. It expects one edge with the maskable winner (or nothing), then index 0 again on the following edge. A control run acknowledges with no new edge and expects the request to stay gone. The same collision is repeated with a maskable source active, to confirm that the offer goes first to that source and is then taken back by the new non-maskable request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    // rank class of an offered request; numerically larger wins
    typedef enum logic [1:0] {
        CLS_LO  = 2'd0,
        CLS_HI  = 2'd1,
        CLS_NMI = 2'd2
    } irq_cls_e;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic nmi_in,
    input  logic clr,
    output logic pend
);

    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_st_t;

    nmi_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        st_d      = st_q;
        rise      = nmi_in & ~st_q.prev;
        st_d.prev = nmi_in;
        if (standby) begin
            st_d.pend = 1'b0;
        end else if (rise) begin
            st_d.pend = 1'b1;
        end else if (clr) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;

    AST_STBY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !pend);                                  // R3
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && !st_q.prev && !standby) |=> pend);        // R12

endmodule

// File: rtl/irq_mask_filter.sv
module irq_mask_filter #(
    parameter int NUM_SRC = 14
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] lvl,
    input  logic               mode_single,
    input  logic               mask_all,
    input  logic               mask_lo,
    output logic [NUM_SRC-1:0] acc
);

    logic pass_lo;
    logic pass_hi;

    always_comb begin
        pass_lo = ~mask_all;
        pass_hi = mode_single ? ~mask_all : (~mask_all | ~mask_lo);
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign acc[s] = req[s] & en[s] & (lvl[s] ? pass_hi : pass_lo);
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 14,
    parameter int POS_W   = 4
) (
    input  logic               nmi,
    input  logic [NUM_SRC-1:0] acc,
    input  logic [NUM_SRC-1:0] lvl,
    output logic               vld,
    output irq_cls_e           cls,
    output logic [POS_W-1:0]   pos
);

    logic             hi_any, lo_any;
    logic [POS_W-1:0] hi_pos, lo_pos;

    always_comb begin
        hi_any = 1'b0;
        lo_any = 1'b0;
        hi_pos = '0;
        lo_pos = '0;
        // scan downward so the lowest index is written last and wins
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (acc[s] && lvl[s]) begin
                hi_any = 1'b1;
                hi_pos = POS_W'(s + 1);
            end
            if (acc[s] && !lvl[s]) begin
                lo_any = 1'b1;
                lo_pos = POS_W'(s + 1);
            end
        end

        vld = 1'b1;
        if (nmi) begin
            cls = CLS_NMI;
            pos = '0;
        end else if (hi_any) begin
            cls = CLS_HI;
            pos = hi_pos;
        end else if (lo_any) begin
            cls = CLS_LO;
            pos = lo_pos;
        end else begin
            vld = 1'b0;
            cls = CLS_LO;
            pos = '0;
        end
    end

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NUM_EXT  = 6,
    parameter int NUM_PERI = 8,
    localparam int NUM_MASK = NUM_EXT + NUM_PERI,
    localparam int NUM_POS  = NUM_MASK + 1,
    localparam int POS_W    = $clog2(NUM_POS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                standby,
    input  logic                nmi_in,
    input  logic [NUM_EXT-1:0]  ext_req,
    input  logic [NUM_PERI-1:0] peri_req,
    input  logic [NUM_MASK-1:0] src_en,
    input  logic [NUM_MASK-1:0] src_lvl,
    input  logic                mode_single,
    input  logic                mask_all,
    input  logic                mask_lo,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [POS_W-1:0]    irq_idx
);

    typedef struct packed {
        logic             req;
        irq_cls_e         cls;
        logic [POS_W-1:0] pos;
    } offer_t;

    offer_t offer_d, offer_q;

    logic                nmi_pend;
    logic                nmi_clr;
    logic                nmi_live;
    logic [NUM_MASK-1:0] acc;
    logic                cand_vld;
    irq_cls_e            cand_cls;
    logic [POS_W-1:0]    cand_pos;
    logic                cand_better;
    logic                reload;

    assign nmi_clr  = irq_ack & offer_q.req & (offer_q.cls == CLS_NMI);
    assign nmi_live = nmi_pend & ~standby & ~nmi_clr;

    irq_nmi_latch u_nmi (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .nmi_in  (nmi_in),
        .clr     (nmi_clr),
        .pend    (nmi_pend)
    );

    irq_mask_filter #(
        .NUM_SRC (NUM_MASK)
    ) u_filt (
        .req         ({peri_req, ext_req}),
        .en          (src_en),
        .lvl         (src_lvl),
        .mode_single (mode_single),
        .mask_all    (mask_all),
        .mask_lo     (mask_lo),
        .acc         (acc)
    );

    irq_prio_pick #(
        .NUM_SRC (NUM_MASK),
        .POS_W   (POS_W)
    ) u_pick (
        .nmi (nmi_live),
        .acc (acc),
        .lvl (src_lvl),
        .vld (cand_vld),
        .cls (cand_cls),
        .pos (cand_pos)
    );

    always_comb begin
        cand_better = cand_vld &&
                      ((cand_cls > offer_q.cls) ||
                       ((cand_cls == offer_q.cls) && (cand_pos < offer_q.pos)));
        reload = ~offer_q.req | irq_ack |
                 ((offer_q.cls == CLS_NMI) & ~nmi_live);

        offer_d = offer_q;
        if (reload || cand_better) begin
            offer_d.req = cand_vld;
            offer_d.cls = cand_cls;
            offer_d.pos = cand_vld ? cand_pos : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offer_q <= '{req: 1'b0, cls: CLS_LO, pos: '0};
        end else begin
            offer_q <= offer_d;
        end
    end

    assign irq_req = offer_q.req;
    assign irq_idx = offer_q.pos;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (int'(irq_idx) < NUM_POS));                          // R10
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_idx == '0));                                   // R1
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack && !standby && !cand_better)
        |=> (irq_req && $stable(irq_idx)));                              // R11
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pend && !standby && !irq_ack) |=> (irq_req && irq_idx == '0)); // R9
    AST_SINGLE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_single && mask_all && !nmi_pend && !irq_req) |=> !irq_req);   // R5
    AST_TWO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_single && mask_all && mask_lo && !nmi_pend && !irq_req)
        |=> !irq_req);                                                   // R8

endmodule

// File: tb/sim_irq_arb_top.sv
`timescale 1ns/1ps
module sim_irq_arb_top;

    localparam int NE = 6;
    localparam int NP = 8;
    localparam int NM = NE + NP;
    localparam int PW = $clog2(NM + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          standby = 1'b0;
    logic          nmi_in = 1'b0;
    logic [NM-1:0] req_all = '0;
    logic [NM-1:0] src_en = '0;
    logic [NM-1:0] src_lvl = '0;
    logic          mode_single = 1'b1;
    logic          mask_all = 1'b0;
    logic          mask_lo = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_req;
    logic [PW-1:0] irq_idx;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    irq_arb_top #(.NUM_EXT(NE), .NUM_PERI(NP)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby     (standby),
        .nmi_in      (nmi_in),
        .ext_req     (req_all[NE-1:0]),
        .peri_req    (req_all[NM-1:NE]),
        .src_en      (src_en),
        .src_lvl     (src_lvl),
        .mode_single (mode_single),
        .mask_all    (mask_all),
        .mask_lo     (mask_lo),
        .irq_ack     (irq_ack),
        .irq_req     (irq_req),
        .irq_idx     (irq_idx)
    );

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string rid, input logic exp_req, input int exp_idx);
        n_chk++;
        if (irq_req !== exp_req || int'(irq_idx) !== exp_idx) begin
            n_err++;
            $display("FAIL %s: req=%0b idx=%0d expected req=%0b idx=%0d",
                     rid, irq_req, irq_idx, exp_req, exp_idx);
        end
    endtask

    task automatic ack_pulse();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic clean();
        req_all = '0;
        nmi_in  = 1'b0;
        standby = 1'b0;
        ack_pulse();
        ack_pulse();
        step();
        mode_single = 1'b1;
        mask_all = 1'b0;
        mask_lo = 1'b0;
        src_en = '1;
        src_lvl = '0;
    endtask

    task automatic t_reset();
        chk("R1 reset", 1'b0, 0);
    endtask

    task automatic t_nmi();
        mode_single = 1'b1; mask_all = 1'b1; mask_lo = 1'b1;
        nmi_in = 1'b1;
        step();
        chk("R2 nmi not yet", 1'b0, 0);
        step();
        chk("R2 nmi masked-all", 1'b1, 0);
        ack_pulse();
        chk("R12 ack clears", 1'b0, 0);
        step(2);
        chk("R2 held level no retrigger", 1'b0, 0);
        clean();
    endtask

    task automatic t_standby();
        standby = 1'b1;
        nmi_in = 1'b1;
        step(2);
        chk("R3 edge in standby", 1'b0, 0);
        standby = 1'b0;
        nmi_in = 1'b0;
        step();
        nmi_in = 1'b1;
        step();
        standby = 1'b1;
        step();
        chk("R3 pending dropped", 1'b0, 0);
        standby = 1'b0;
        step(2);
        chk("R3 stays dropped", 1'b0, 0);
        clean();
    endtask

    task automatic t_enable();
        src_en = '1;
        src_en[2] = 1'b0;
        src_en[NE+3] = 1'b0;
        req_all[2] = 1'b1;
        req_all[NE+3] = 1'b1;
        step();
        chk("R4 disabled ignored", 1'b0, 0);
        src_en[NE+3] = 1'b1;
        step();
        chk("R4 enabled peri3", 1'b1, 7 + 3);
        clean();
    endtask

    task automatic t_single();
        mode_single = 1'b1; mask_all = 1'b0; mask_lo = 1'b1;
        req_all[3] = 1'b1;
        step();
        chk("R5 single open", 1'b1, 4);
        clean();
        mode_single = 1'b1; mask_all = 1'b1; mask_lo = 1'b0;
        req_all[3] = 1'b1;
        req_all[NE+1] = 1'b1;
        src_lvl[NE+1] = 1'b1;
        step(2);
        chk("R5 single masked incl level1", 1'b0, 0);
        clean();
    endtask

    task automatic t_two();
        mode_single = 1'b0; mask_all = 1'b0; mask_lo = 1'b1;
        req_all[1] = 1'b1;
        step();
        chk("R6 two-level open", 1'b1, 2);
        clean();
        mode_single = 1'b0; mask_all = 1'b1; mask_lo = 1'b0;
        req_all[1] = 1'b1;
        step();
        chk("R7 level0 blocked", 1'b0, 0);
        req_all[NE+2] = 1'b1;
        src_lvl[NE+2] = 1'b1;
        step();
        chk("R7 level1 passes", 1'b1, 9);
        clean();
        mode_single = 1'b0; mask_all = 1'b1; mask_lo = 1'b1;
        req_all[NE+2] = 1'b1;
        src_lvl[NE+2] = 1'b1;
        step(2);
        chk("R8 both masked", 1'b0, 0);
        clean();
    endtask

    task automatic t_prio();
        req_all[0] = 1'b1;
        req_all[NE+5] = 1'b1;
        src_lvl[NE+5] = 1'b1;
        step();
        chk("R9 level1 beats level0", 1'b1, 12);
        clean();
        req_all[4] = 1'b1;
        req_all[2] = 1'b1;
        step();
        chk("R10 ext order", 1'b1, 3);
        clean();
        req_all[NE+6] = 1'b1;
        req_all[NE+1] = 1'b1;
        step();
        chk("R10 peri order", 1'b1, 8);
        clean();
        req_all[NE] = 1'b1;
        req_all[5] = 1'b1;
        step();
        chk("R10 ext before peri", 1'b1, 6);
        nmi_in = 1'b1;
        step(2);
        chk("R9 nmi replaces", 1'b1, 0);
        clean();
    endtask

    task automatic t_hold();
        req_all[1] = 1'b1;
        step();
        chk("R11 offer", 1'b1, 2);
        req_all[4] = 1'b1;
        step();
        chk("R11 lower rank no effect", 1'b1, 2);
        req_all[1] = 1'b0;
        step();
        chk("R11 source dropped held", 1'b1, 2);
        req_all[NE] = 1'b1;
        src_lvl[NE] = 1'b1;
        step();
        chk("R11 higher replaces", 1'b1, 7);
        ack_pulse();
        chk("R11 reoffer after ack", 1'b1, 7);
        req_all[NE] = 1'b0;
        ack_pulse();
        chk("R11 next after ack", 1'b1, 5);
        clean();
    endtask

    task automatic t_collide();
        nmi_in = 1'b1;
        step(2);
        chk("R12 nmi offered", 1'b1, 0);
        nmi_in = 1'b0;
        step();
        nmi_in = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R12 ack edge gap", 1'b0, 0);
        step();
        chk("R12 edge kept pending", 1'b1, 0);
        ack_pulse();
        step(2);
        chk("R12 control no edge", 1'b0, 0);
        nmi_in = 1'b0;
        req_all[0] = 1'b1;
        step();
        nmi_in = 1'b1;
        step(2);
        chk("R12 nmi over ext0", 1'b1, 0);
        nmi_in = 1'b0;
        step();
        nmi_in = 1'b1;
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
        chk("R12 ext0 offered at ack", 1'b1, 1);
        step();
        chk("R12 nmi retakes", 1'b1, 0);
        clean();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : main
        src_en = '1;
        step(2);
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_nmi();
        t_standby();
        t_enable();
        t_single();
        t_two();
        t_prio();
        t_hold();
        t_collide();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule